// File: doc/BRIEF.md
# Aliased Stack / Packed Register File

This block holds eight 80-bit data registers that can be reached through two views at once. The stack view treats them as a circular push/pop stack. A 3-bit top pointer selects the current entry, and a 16-bit tag vector gives each register a 2-bit occupancy code. The packed view addresses the same registers directly by index as eight 64-bit registers. This direct index does not depend on the top pointer.

Every packed operation except the empty command disturbs the shared state in three ways. It forces the top pointer to 0. It marks all eight tags valid. A packed write also fills bits 79:64 of its target with ones. A value placed through one view can therefore be corrupted when it is seen through the other.

Commands arrive on a valid/ready port, one per cycle. The block never applies back-pressure: `cmd_ready` is always high, and a command takes effect on the rising edge where `cmd_valid` is high. Read data is combinational. It reflects the command presented in the current cycle and the state before that edge.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous reset clears all eight registers, sets the top pointer to 0, sets every tag to empty (2'b11), and clears both flags.
- R2: `cmd_ready` is always 1. The opcodes are 0 none, 1 push, 2 pop, 3 stack read, 4 packed write, 5 packed read, 6 empty, and 7 none. If `cmd_valid` is low, or the opcode is 0 or 7, the block changes no state.
- R3: A packed write or packed read sets the top pointer to 0 on the clock edge.
- R4: A packed write or packed read sets all eight tag fields to valid (2'b00). The tag of register i is `tag_o[2i+1:2i]`.
- R5: A packed write to index n stores `cmd_data[63:0]` into bits 63:0 of register n and all ones into bits 79:64. Register n is chosen directly and does not depend on the top pointer.
- R6: During a packed read, `rd_data` equals {16'h0, bits 63:0 of register `cmd_idx`} in the same cycle.
- R7: The empty command sets every tag to 2'b11. It leaves the register contents and the top pointer unchanged.
- R8: A push whose target is empty does three things: it decrements the top pointer modulo 8, writes all 80 bits of `cmd_data` to the new top, and marks that register valid. For every opcode other than packed read, `rd_data` shows the register at the top pointer.
- R9: A pop of a valid top marks that register empty and increments the top pointer modulo 8.
- R10: A push whose target register (top−1 mod 8) is not empty sets the sticky `ovf_o` flag. It writes nothing and does not move the pointer.
- R11: A pop or stack read of an empty top sets the sticky `unf_o` flag. A pop in this case changes nothing else.
- R12: `flag_clr` clears both flags on the clock edge. A flag set by the command in the same cycle takes priority and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always high |
| cmd_op | input | 3 | Opcode |
| cmd_idx | input | 3 | Direct register index for packed operations |
| cmd_data | input | 80 | Write data (packed write uses bits 63:0) |
| flag_clr | input | 1 | Clear sticky flags |
| rd_data | output | 80 | Combinational read data |
| top_o | output | 3 | Stack top pointer |
| tag_o | output | 16 | Tag vector, 2 bits per register |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
Two things can land on the same edge: a command that raises a flag, and `flag_clr`. The bench provokes this with a directed case that issues a ninth push onto a full stack while clear is held. It then checks that `ovf_o` stays high, and in the next cycle that clear alone drops it. The random phase also asserts `flag_clr` at random alongside every kind of command, and judges the flags against a reference model. The model applies set-wins-over-clear on each edge.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_PEEK  = 3'd3,
    OP_PK_WR = 3'd4,
    OP_PK_RD = 3'd5,
    OP_EMPTY = 3'd6,
    OP_RSVD  = 3'd7
  } arf_op_e;

  localparam logic [1:0] TAG_VALID = 2'b00;
  localparam logic [1:0] TAG_EMPTY = 2'b11;
endpackage

// File: rtl/arf_storage.sv
module arf_storage #(
  parameter int NREG  = 8,
  parameter int WIDTH = 80,
  localparam int IW   = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IW-1:0]               widx,
  input  logic [WIDTH-1:0]            wdata,
  output logic [NREG-1:0][WIDTH-1:0]  regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_o[g] <= '0;
      else if (we && (widx == IW'(g)))
        regs_o[g] <= wdata;
    end
  end
endmodule

// File: rtl/arf_ctl.sv
module arf_ctl
  import arf_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int WIDTH = 80,
  parameter int PW    = 64,
  localparam int IW   = $clog2(NREG),
  localparam int TW   = 2 * NREG,
  localparam int EW   = WIDTH - PW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IW-1:0]    cmd_idx,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic             flag_clr,
  output logic             we,
  output logic [IW-1:0]    widx,
  output logic [WIDTH-1:0] wdata,
  output logic [IW-1:0]    top_q,
  output logic [TW-1:0]    tag_q,
  output logic             ovf_q,
  output logic             unf_q
);
  arf_op_e          op;
  logic [IW-1:0]    top_n, below;
  logic [TW-1:0]    tag_n;
  logic             ovf_set, unf_set;
  logic             top_empty, below_empty;

  assign op          = arf_op_e'(cmd_op);
  assign below       = top_q - IW'(1);
  assign top_empty   = (tag_q[2*top_q +: 2] == TAG_EMPTY);
  assign below_empty = (tag_q[2*below +: 2] == TAG_EMPTY);

  always_comb begin
    top_n   = top_q;
    tag_n   = tag_q;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    we      = 1'b0;
    widx    = top_q;
    wdata   = cmd_data;
    if (cmd_valid) begin
      unique case (op)
        OP_PUSH: begin
          if (below_empty) begin
            top_n              = below;
            tag_n[2*below +: 2] = TAG_VALID;
            we                 = 1'b1;
            widx               = below;
          end else begin
            ovf_set = 1'b1;
          end
        end
        OP_POP: begin
          if (top_empty) begin
            unf_set = 1'b1;
          end else begin
            tag_n[2*top_q +: 2] = TAG_EMPTY;
            top_n               = top_q + IW'(1);
          end
        end
        OP_PEEK: unf_set = top_empty;
        OP_PK_WR: begin
          top_n = '0;
          tag_n = {NREG{TAG_VALID}};
          we    = 1'b1;
          widx  = cmd_idx;
          wdata = {{EW{1'b1}}, cmd_data[PW-1:0]};
        end
        OP_PK_RD: begin
          top_n = '0;
          tag_n = {NREG{TAG_VALID}};
        end
        OP_EMPTY: tag_n = {NREG{TAG_EMPTY}};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
      tag_q <= {NREG{TAG_EMPTY}};
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      top_q <= top_n;
      tag_q <= tag_n;
      ovf_q <= (ovf_q && !flag_clr) || ovf_set;
      unf_q <= (unf_q && !flag_clr) || unf_set;
    end
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import arf_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int WIDTH = 80,
  parameter int PW    = 64,
  localparam int IW   = $clog2(NREG),
  localparam int TW   = 2 * NREG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [IW-1:0]    cmd_idx,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic             flag_clr,
  output logic [WIDTH-1:0] rd_data,
  output logic [IW-1:0]    top_o,
  output logic [TW-1:0]    tag_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic                       we;
  logic [IW-1:0]              widx;
  logic [WIDTH-1:0]           wdata;
  logic [NREG-1:0][WIDTH-1:0] regs;

  assign cmd_ready = 1'b1;

  arf_ctl #(.NREG(NREG), .WIDTH(WIDTH), .PW(PW)) u_ctl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .flag_clr(flag_clr),
    .we(we), .widx(widx), .wdata(wdata),
    .top_q(top_o), .tag_q(tag_o), .ovf_q(ovf_o), .unf_q(unf_o)
  );

  arf_storage #(.NREG(NREG), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .we(we), .widx(widx), .wdata(wdata), .regs_o(regs)
  );

  // Packed view sees the low PW bits of a directly indexed register.
  always_comb begin
    if (arf_op_e'(cmd_op) == OP_PK_RD)
      rd_data = {{(WIDTH-PW){1'b0}}, regs[cmd_idx][PW-1:0]};
    else
      rd_data = regs[top_o];
  end
endmodule

// File: rtl/arf_checker.sv
module arf_checker #(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG),
  localparam int TW  = 2 * NREG
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          flag_clr,
  input logic [IW-1:0] top_o,
  input logic [TW-1:0] tag_o,
  input logic          ovf_o,
  input logic          unf_o
);
  logic [IW-1:0] tgt;
  logic          tgt_empty;
  logic          pk_op;
  assign tgt       = top_o - IW'(1);
  assign tgt_empty = (tag_o[2*tgt +: 2] == 2'b11);
  assign pk_op     = cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (top_o == '0 && tag_o == {TW{1'b1}} && !ovf_o && !unf_o));

  a_r3_pk_top_zero: assert property (@(posedge clk) disable iff (rst)
    pk_op |=> top_o == '0);

  a_r4_pk_tags_valid: assert property (@(posedge clk) disable iff (rst)
    pk_op |=> tag_o == '0);

  a_r7_empty_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd6) |=> (tag_o == {TW{1'b1}} && $stable(top_o)));

  a_r8_push_moves: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1 && tgt_empty) |=> top_o == $past(tgt));

  a_r10_push_full: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1 && !tgt_empty) |=> (ovf_o && $stable(top_o)));

  a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !flag_clr) |=> ovf_o);

  a_r12_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    (unf_o && !flag_clr) |=> unf_o);
endmodule

bind alias_regfile arf_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .flag_clr(flag_clr), .top_o(top_o), .tag_o(tag_o),
  .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/sim_alias_regfile.sv
module sim_alias_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [2:0]  cmd_idx;
  logic [79:0] cmd_data;
  logic        flag_clr;
  logic [79:0] rd_data;
  logic [2:0]  top_o;
  logic [15:0] tag_o;
  logic        ovf_o, unf_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [79:0] mreg [8];
  logic [2:0]  mtop;
  logic [15:0] mtag;
  logic        movf, munf;

  always #4 clk = ~clk;

  alias_regfile u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .flag_clr(flag_clr), .rd_data(rd_data), .top_o(top_o), .tag_o(tag_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic check(string req, string what, logic [79:0] act, logic [79:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [79:0] model_rd(logic [2:0] op, logic [2:0] idx);
    if (op == 3'd5) return {16'h0, mreg[idx][63:0]};
    return mreg[mtop];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    mtop = 0; mtag = 16'hFFFF; movf = 0; munf = 0;
  endtask

  task automatic model_edge(logic v, logic [2:0] op, logic [2:0] idx,
                            logic [79:0] d, logic clr);
    logic [2:0] b;
    logic os, us;
    os = 0; us = 0;
    b = mtop - 3'd1;
    if (v) begin
      case (op)
        3'd1: if (mtag[2*b +: 2] == 2'b11) begin
                mtop = b; mtag[2*b +: 2] = 2'b00; mreg[b] = d;
              end else os = 1;
        3'd2: if (mtag[2*mtop +: 2] == 2'b11) us = 1;
              else begin mtag[2*mtop +: 2] = 2'b11; mtop = mtop + 3'd1; end
        3'd3: us = (mtag[2*mtop +: 2] == 2'b11);
        3'd4: begin mtop = 0; mtag = '0; mreg[idx] = {16'hFFFF, d[63:0]}; end
        3'd5: begin mtop = 0; mtag = '0; end
        3'd6: mtag = 16'hFFFF;
        default: ;
      endcase
    end
    movf = (movf && !clr) || os;
    munf = (munf && !clr) || us;
  endtask

  task automatic step(string req, logic v, logic [2:0] op, logic [2:0] idx,
                      logic [79:0] d, logic clr);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_idx = idx; cmd_data = d; flag_clr = clr;
    #1;
    check(req, "ready", {79'h0, cmd_ready}, 80'h1);
    check(req, "rd_data", rd_data, model_rd(op, idx));
    @(posedge clk);
    model_edge(v, op, idx, d, clr);
    #2;
    check(req, "top", {77'h0, top_o}, {77'h0, mtop});
    check(req, "tag", {64'h0, tag_o}, {64'h0, mtag});
    check(req, "ovf", {79'h0, ovf_o}, {79'h0, movf});
    check(req, "unf", {79'h0, unf_o}, {79'h0, munf});
  endtask

  function automatic logic [79:0] rnd80();
    return {$urandom, $urandom, $urandom};
  endfunction

  initial begin
    #1_600_000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1; cmd_valid = 0; cmd_op = 0; cmd_idx = 0; cmd_data = '0; flag_clr = 0;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1", "top", {77'h0, top_o}, 80'h0);
    check("R1", "tag", {64'h0, tag_o}, 80'hFFFF);
    check("R1", "flags", {78'h0, ovf_o, unf_o}, 80'h0);
    check("R1", "rd_data", rd_data, 80'h0);

    step("R11", 1, 3'd2, 0, '0, 0);                 // pop empty
    step("R11", 1, 3'd3, 0, '0, 0);                 // peek empty
    step("R12", 0, 3'd0, 0, '0, 1);                 // clear
    step("R2",  0, 3'd1, 0, 80'h1234, 0);           // not valid: no effect
    step("R2",  1, 3'd7, 0, 80'h1234, 0);           // reserved op
    for (int i = 0; i < 8; i++)
      step("R8", 1, 3'd1, 0, {16'hA5A5, 32'(i), 32'hC0DE0000 + 32'(i)}, 0);
    step("R10", 1, 3'd1, 0, 80'hDEAD, 1);           // overflow with clear: set wins
    step("R12", 1, 3'd0, 0, '0, 1);                 // clear drops it
    step("R8",  1, 3'd3, 0, '0, 0);                 // peek top
    step("R9",  1, 3'd2, 0, '0, 0);
    step("R9",  1, 3'd2, 0, '0, 0);
    step("R7",  1, 3'd6, 0, '0, 0);
    step("R11", 1, 3'd2, 0, '0, 0);
    step("R5",  1, 3'd4, 3'd5, 80'h0123_4567_89AB_CDEF_1357, 0);
    step("R6",  1, 3'd5, 3'd5, '0, 0);
    step("R3",  1, 3'd5, 3'd2, '0, 0);
    step("R4",  1, 3'd1, 0, 80'h77, 0);             // all valid -> overflow
    step("R12", 1, 3'd0, 0, '0, 1);
    step("R7",  1, 3'd6, 0, '0, 0);
    step("R8",  1, 3'd1, 0, 80'hFACE_0000_0000_0000_BEEF, 0); // wraps to 7

    for (int n = 0; n < 4000; n++) begin
      logic [2:0] op;
      string r;
      op = 3'($urandom % 8);
      case (op)
        3'd1: r = "R8"; 3'd2: r = "R9"; 3'd3: r = "R11";
        3'd4: r = "R5"; 3'd5: r = "R6"; 3'd6: r = "R7";
        default: r = "R2";
      endcase
      step(r, ($urandom % 8) != 0, op, 3'($urandom), rnd80(), ($urandom % 6) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule